// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a serial-bus target that gives a host controller access to a bank of nineteen byte-wide configuration registers inside a clock generator. It answers only at one fixed 7-bit device address. The command byte picks one of two access styles. In indexed mode the host reaches a single register by its offset. In sequential mode every transfer starts at offset 0 and moves upward one register per byte. In sequential mode the write carries a count byte, and the read returns a count byte before the data.

The block samples the bus clock and data lines with the fast system clock and pulls the data line low through an open-drain enable. Every register loads its default on reset, so the host does not have to program anything. A few bit fields are read-only and show live hardware status: the latched frequency-select code and three strap levels. The full readable contents of the bank are also presented in parallel to the logic that the registers control.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset, `sda_oe` is low and the registers read (offset:value, hex) 0:01, 1:02, 2:FF, 3:FF, 4:FF, 5:00, 6:00, 7:18, 8:00, 9:25, 10:7F, 11:05, 12:0D, 13:CB, 14..17:00, 18:40, with the read-only fields of R8 overlaid. Byte i of the bank appears on `cfg_o[8*i+7:8*i]`.
- R2: The target acknowledges address byte D2h (7-bit 69h, write) and D3h (read). It acknowledges no other address, and the rest of that transaction has no effect on any register.
- R3: Indexed write: a command byte with bit 7 = 1 selects the offset in bits 6:0. The next data byte is acknowledged and written to that offset.
- R4: Indexed read: start, D2h, command (bit 7 = 1, offset), repeated start, D3h. The target returns the register at that offset, MSB first. The host NACKs that byte and then sends stop.
- R5: Sequential write: a command byte with bit 7 = 0 is followed by a count byte. The count byte is acknowledged and is not stored. The data bytes then go to offsets 0, 1, 2 and upward, each one acknowledged. A stop after any complete byte leaves the higher offsets unchanged.
- R6: Sequential read: after a command with bit 7 = 0, a repeated start and D3h, the target first returns the count held in offset 12, bits 5:0. It then returns offsets 0, 1, 2 and upward.
- R7: In a sequential read, every byte requested beyond the count returns 00h.
- R8: Read-only fields: offset 0 bits 7:5 show `hw_fsel`, offset 10 bit 7 shows `hw_strap[0]`, and offset 11 bits 7:6 show `hw_strap[2:1]`. These fields follow the inputs live, and writes to them are ignored.
- R9: Offset 12 bits 7:6 always read 0, and writes to them are ignored.
- R10: Offsets 19 and above read 00h. Writes to them are acknowledged and change no register.
- R11: `sda_oe` changes only while SCL is low, and it is released after the target's final bit of a read.
- R12: A command with bit 7 = 0 starts at offset 0 even when its bits 6:0 are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| hw_fsel | input | 3 | Latched frequency-select code, read-only field |
| hw_strap | input | 3 | Strap status levels, read-only fields |
| cfg_o | output | 152 | Readable contents of all registers, byte i at bits 8i+7:8i |

## Verification
The assertions check four things on every cycle:
- the data-line drive changes only while SCL is low;
- the reserved count bits stay zero;
- the frequency-select field mirrors its input;
- the writable register contents change only during the SCL low phase.

Only the directed scenarios can show:
- address filtering;
- the indexed and sequential orderings;
- the count byte being consumed on writes and returned on reads;
- the zero fill past the count and beyond the last offset;
- partial sequential writes;
- the rule that a command with bit 7 = 0 starts at offset 0.

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter int NREG = 19,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int CNT_IDX = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [2:0]      hw_fsel,
  input  logic [2:0]      hw_strap,
  output logic [NREG*8-1:0] cfg_o
);

  localparam int PW = 7;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_SKIP} st_t;

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: dflt = 8'h01;
      1: dflt = 8'h02;
      2, 3, 4: dflt = 8'hFF;
      7: dflt = 8'h18;
      9: dflt = 8'h25;
      10: dflt = 8'h7F;
      11: dflt = 8'h05;
      CNT_IDX: dflt = 8'h0D;
      13: dflt = 8'hCB;
      18: dflt = 8'h40;
      default: dflt = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0: wmask = 8'h1F;
      10: wmask = 8'h7F;
      11: wmask = 8'h3F;
      CNT_IDX: wmask = 8'h3F;
      default: wmask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] ro_bits(input int i, input logic [2:0] fs, input logic [2:0] sp);
    case (i)
      0: ro_bits = {fs, 5'b0};
      10: ro_bits = {sp[0], 7'b0};
      11: ro_bits = {sp[2:1], 6'b0};
      default: ro_bits = 8'h00;
    endcase
  endfunction

  logic [1:0] scl_q, sda_q;
  logic       p_scl, p_sda;
  logic       s_scl, s_sda;
  logic       scl_r, scl_f, start, stop;

  st_t        st;
  logic [7:0] sh;
  logic [3:0] bitn;
  logic       in_ack, m_ack;
  logic       blk;
  logic [PW-1:0] ptr;
  logic [5:0] rem;

  logic [7:0] regs [NREG];
  logic [7:0] rdv  [NREG];
  logic [7:0] cur_rd, nb;
  logic [5:0] bcnt;
  logic       byte_end, adr_hit, adr_rd, nxt_ld, cmd_done, wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      p_scl <= 1'b1;
      p_sda <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      p_scl <= scl_q[1];
      p_sda <= sda_q[1];
    end
  end

  assign s_scl = scl_q[1];
  assign s_sda = sda_q[1];
  assign scl_r = s_scl & ~p_scl;
  assign scl_f = ~s_scl & p_scl;
  assign start = s_scl & p_scl & p_sda & ~s_sda;
  assign stop  = s_scl & p_scl & ~p_sda & s_sda;

  assign byte_end = !in_ack && scl_f && bitn == 4'd8;
  assign adr_hit  = sh[7:1] == DEV_ADDR;
  assign adr_rd   = st == S_ADDR && byte_end && adr_hit && sh[0];
  assign nxt_ld   = st == S_RD && !in_ack && m_ack && scl_f;
  assign cmd_done = st == S_CMD && byte_end;
  assign wr_done  = st == S_WR && byte_end;

  for (genvar g = 0; g < NREG; g++) begin : g_rd
    assign rdv[g] = regs[g] | ro_bits(g, hw_fsel, hw_strap);
    assign cfg_o[g*8 +: 8] = rdv[g];
  end

  always_comb begin
    cur_rd = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == PW'(i)) cur_rd = rdv[i];
  end

  assign bcnt = rdv[CNT_IDX][5:0];
  assign nb = (adr_rd && blk) ? {2'b00, bcnt} :
              (blk && rem == 6'd0) ? 8'h00 : cur_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= 8'h00;
      bitn   <= 4'd0;
      in_ack <= 1'b0;
      m_ack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start) begin
      st     <= S_ADDR;
      bitn   <= 4'd0;
      in_ack <= 1'b0;
      m_ack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      in_ack <= 1'b0;
      m_ack  <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_CNT, S_WR: begin
          if (in_ack) begin
            if (scl_f) begin
              in_ack <= 1'b0;
              sda_oe <= 1'b0;
              bitn   <= 4'd0;
            end
          end else if (scl_r) begin
            sh   <= {sh[6:0], s_sda};
            bitn <= bitn + 4'd1;
          end else if (byte_end) begin
            bitn   <= 4'd0;
            in_ack <= 1'b1;
            sda_oe <= 1'b1;
            case (st)
              S_ADDR: begin
                if (!adr_hit) begin
                  st     <= S_SKIP;
                  in_ack <= 1'b0;
                  sda_oe <= 1'b0;
                end else if (sh[0]) begin
                  st <= S_RD;
                  sh <= nb;
                end else begin
                  st <= S_CMD;
                end
              end
              S_CMD:   st <= sh[7] ? S_WR : S_CNT;
              S_CNT:   st <= S_WR;
              default: st <= S_WR;
            endcase
          end
        end
        S_RD: begin
          if (in_ack) begin
            if (scl_f) begin
              in_ack <= 1'b0;
              sda_oe <= ~sh[7];
              bitn   <= 4'd0;
            end
          end else if (m_ack) begin
            if (scl_r && s_sda) begin
              st    <= S_SKIP;
              m_ack <= 1'b0;
            end else if (scl_f) begin
              m_ack  <= 1'b0;
              sh     <= nb;
              sda_oe <= ~nb[7];
              bitn   <= 4'd0;
            end
          end else if (scl_r) begin
            bitn <= bitn + 4'd1;
          end else if (scl_f) begin
            if (bitn == 4'd8) begin
              sda_oe <= 1'b0;
              m_ack  <= 1'b1;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk <= 1'b0;
      ptr <= '0;
      rem <= 6'd0;
    end else if (cmd_done) begin
      blk <= ~sh[7];
      ptr <= sh[7] ? sh[6:0] : '0;
    end else if (wr_done) begin
      ptr <= ptr + PW'(1);
    end else if (adr_rd && blk) begin
      ptr <= '0;
      rem <= bcnt;
    end else if (adr_rd || nxt_ld) begin
      ptr <= ptr + PW'(1);
      if (blk && rem != 6'd0) rem <= rem - 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i) & wmask(i);
    end else if (wr_done) begin
      for (int i = 0; i < NREG; i++)
        if (ptr == PW'(i)) regs[i] <= sh & wmask(i);
    end
  end

endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk #(
  parameter int NREG = 19,
  parameter int CNT_IDX = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [2:0]        hw_fsel,
  input logic [NREG*8-1:0] cfg_o
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_release_chk: assert (!sda_oe);
    end
  end

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R9
  cnt_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[CNT_IDX*8+7 -: 2] == 2'b00);

  // R8
  fsel_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7:5] == hw_fsel);

  // R3
  low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o[79:8]) |-> !scl_i);

  // R5
  high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o[NREG*8-1:96]) |-> !scl_i);

endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NREG(NREG), .CNT_IDX(CNT_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .hw_fsel(hw_fsel), .cfg_o(cfg_o)
);

// File: tb/sim_smb_cfg_target.sv
`timescale 1ns/1ps
module sim_smb_cfg_target;
  localparam int N = 19;
  localparam time Q = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe, sda_bus;
  logic [2:0] fsel = 3'b101, strap = 3'b010;
  logic [N*8-1:0] cfg;
  logic [7:0] mdl [N];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  smb_cfg_target u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe),
                     .hw_fsel(fsel), .hw_strap(strap), .cfg_o(cfg));

  function automatic logic [7:0] exp_rd(input int i);
    if (i >= N) return 8'h00;
    case (i)
      0: return {fsel, mdl[0][4:0]};
      10: return {strap[0], mdl[10][6:0]};
      11: return {strap[2:1], mdl[11][5:0]};
      12: return {2'b00, mdl[12][5:0]};
      default: return mdl[i];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hbit(input logic b, output logic s);
    sda_h = b; #Q; scl_h = 1'b1; #Q; s = sda_bus; #Q; scl_h = 1'b0; #Q;
  endtask
  task automatic hstart;
    sda_h = 1'b1; #Q; scl_h = 1'b1; #Q; sda_h = 1'b0; #Q; scl_h = 1'b0; #Q;
  endtask
  task automatic hstop;
    sda_h = 1'b0; #Q; scl_h = 1'b1; #Q; sda_h = 1'b1; #Q;
  endtask
  task automatic wb(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) hbit(d[i], s);
    hbit(1'b1, s);
    ack = ~s;
  endtask
  task automatic rb(input logic last, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin hbit(1'b1, s); d[i] = s; end
    hbit(last, s);
  endtask

  task automatic wr_byte(input logic [6:0] off, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    hstart; wb(8'hD2, a1); wb({1'b1, off}, a2); wb(d, a3); hstop;
    ok = a1 & a2 & a3;
    if (off < N) mdl[off] = d;
  endtask
  task automatic rd_byte(input logic [6:0] off, output logic [7:0] d);
    logic a;
    hstart; wb(8'hD2, a); wb({1'b1, off}, a); hstart; wb(8'hD3, a); rb(1'b1, d); hstop;
  endtask

  task automatic t_reset;
    chk("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
    for (int i = 0; i < N; i++) chk($sformatf("R1 byte%0d", i), cfg[i*8 +: 8], exp_rd(i));
  endtask

  task automatic t_addr;
    logic a;
    hstart; wb(8'hA0, a);
    chk("R2 foreign ack", {7'b0, a}, 8'h00);
    wb(8'h83, a); wb(8'h11, a); hstop;
    chk("R2 byte3 untouched", cfg[3*8 +: 8], exp_rd(3));
    hstart; wb(8'hD2, a); hstop;
    chk("R2 own ack", {7'b0, a}, 8'h01);
  endtask

  task automatic t_byte_wr;
    logic ok;
    wr_byte(7'd3, 8'h5A, ok);
    chk("R3 ack", {7'b0, ok}, 8'h01);
    chk("R3 byte3", cfg[3*8 +: 8], 8'h5A);
    wr_byte(7'd17, 8'hC3, ok);
    chk("R3 byte17", cfg[17*8 +: 8], 8'hC3);
  endtask

  task automatic t_byte_rd;
    logic [7:0] d;
    rd_byte(7'd3, d);  chk("R4 read3", d, 8'h5A);
    rd_byte(7'd17, d); chk("R4 read17", d, 8'hC3);
    rd_byte(7'd9, d);  chk("R4 read9", d, 8'h25);
    chk("R11 released", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic t_ro;
    logic ok;
    logic [7:0] d;
    wr_byte(7'd0, 8'hFF, ok);
    chk("R8 byte0 write", cfg[7:0], {fsel, 5'h1F});
    fsel = 3'b010;
    rd_byte(7'd0, d); chk("R8 live fsel", d, 8'h5F);
    wr_byte(7'd11, 8'hFF, ok);
    rd_byte(7'd11, d); chk("R8 strap field", d, {strap[2:1], 6'h3F});
    wr_byte(7'd10, 8'h00, ok);
    strap = 3'b011;
    rd_byte(7'd10, d); chk("R8 strap0", d, 8'h80);
    wr_byte(7'd12, 8'hFF, ok);
    rd_byte(7'd12, d); chk("R9 count rsvd", d, 8'h3F);
    wr_byte(7'd12, 8'h05, ok);
    chk("R9 count set", cfg[12*8 +: 8], 8'h05);
  endtask

  task automatic t_oor;
    logic ok;
    logic [7:0] d;
    logic [N*8-1:0] snap;
    snap = cfg;
    wr_byte(7'h20, 8'h77, ok);
    chk("R10 ack", {7'b0, ok}, 8'h01);
    chk("R10 no change", {7'b0, cfg == snap}, 8'h01);
    rd_byte(7'h20, d); chk("R10 read zero", d, 8'h00);
    rd_byte(7'd18, d); chk("R10 last valid", d, 8'h40);
  endtask

  task automatic t_blk_wr;
    logic a;
    logic all = 1'b1;
    hstart; wb(8'hD2, a); wb(8'h00, a); all &= a; wb(8'h04, a); all &= a;
    for (int i = 0; i < 4; i++) begin wb(8'hA0 + 8'(i), a); all &= a; mdl[i] = 8'hA0 + 8'(i); end
    hstop;
    chk("R5 acks", {7'b0, all}, 8'h01);
    for (int i = 0; i < 4; i++) chk("R5 seq byte", cfg[i*8 +: 8], exp_rd(i));
    chk("R5 count not stored", cfg[12*8 +: 8], 8'h05);
    hstart; wb(8'hD2, a); wb(8'h05, a); wb(8'h06, a); wb(8'hB0, a); wb(8'hB1, a); hstop;
    mdl[0] = 8'hB0; mdl[1] = 8'hB1;
    chk("R12 from offset0", cfg[7:0], exp_rd(0));
    chk("R12 byte1", cfg[15:8], 8'hB1);
    chk("R5 partial stop", cfg[23:16], 8'hA2);
  endtask

  task automatic t_blk_rd;
    logic a;
    logic [7:0] d;
    hstart; wb(8'hD2, a); wb(8'h00, a); hstart; wb(8'hD3, a);
    rb(1'b0, d); chk("R6 count first", d, 8'h05);
    for (int i = 0; i < 5; i++) begin
      rb(1'b0, d); chk($sformatf("R6 data%0d", i), d, exp_rd(i));
    end
    rb(1'b0, d); chk("R7 past count", d, 8'h00);
    rb(1'b1, d); chk("R7 past count last", d, 8'h00);
    hstop;
    chk("R11 released blk", {7'b0, sda_oe}, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h01; mdl[1] = 8'h02; mdl[2] = 8'hFF; mdl[3] = 8'hFF; mdl[4] = 8'hFF;
    mdl[7] = 8'h18; mdl[9] = 8'h25; mdl[10] = 8'h7F; mdl[11] = 8'h05; mdl[12] = 8'h0D;
    mdl[13] = 8'hCB; mdl[18] = 8'h40;
    #53 rst_n = 1'b1;
    #100;
    t_reset;
    t_addr;
    t_byte_wr;
    t_byte_rd;
    t_ro;
    t_oor;
    t_blk_wr;
    t_blk_rd;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog R1..all act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule